// File: doc/BRIEF.md
# Coefficient RAM Write Arbiter

This block sits between a host register window and the coefficient memory of a sample-based audio DSP. The host stages a target coefficient address and a 24-bit value in byte-wide registers, then raises a request bit. The value is not written at once. The arbiter holds the request and commits it only on the boundary strobe that marks the end of the DSP's per-sample instruction sequence. As a result, at most one coefficient lands per audio sample. A filter section with five coefficients therefore needs five sample periods to load.

The DSP reads coefficients through its own address port. While the DSP clock is absent, every request is discarded and the memory keeps its contents. The host sees memory contents through a readback register set that is refreshed lazily. Each bus write moves a two-stage fetch pipeline on by one step, so a changed word reaches the host only after two further bus writes.

Top module: `coef_write_arbiter`

## Requirements
- R1: After reset, the control register (bus address 0x01) reads 0, the readback bytes (0x06..0x08) read 0, and every coefficient word reads 0 on the DSP port.
- R2: Bus writes to 0x02 set the staged coefficient address (low 6 bits). Writes to 0x03, 0x04 and 0x05 set bits 23:16, 15:8 and 7:0 of the staged value. Each of these registers reads back what was written.
- R3: Writing 0x01 with bit 0 set while dsp_clk_ok is high makes bit 0 of register 0x01 read 1. It stays 1 until the request completes or is dropped.
- R4: A pending request commits only on a cycle with sample_done high. In that same edge, the staged value is stored at the staged address and visible on dsp_rd_data, and request bit 0 reads 0. Without a strobe, the memory does not change.
- R5: A request written in a strobe cycle is not committed by that strobe. It stays pending, also when it re-arms a request that commits in that cycle, and it commits on the next strobe.
- R6: While dsp_clk_ok is low, a request write is dropped and reads 0. If dsp_clk_ok goes low while a request is pending, the request clears. In both cases no memory word changes, even on later strobes.
- R7: Staging writes made while a request is pending replace the staged value. The commit stores the latest value.
- R8: Staged addresses outside 0x00–0x17, 0x20–0x29 and 0x2C–0x2D are accepted, and their commit clears the request, but no memory word changes.
- R9: A changed memory word at the staged address reaches readback bytes 0x06..0x08 (bits 23:16, 15:8, 7:0) only after the second bus write that follows the change.
- R10: A staging write in the same cycle as a commit does not affect that commit. The new value remains staged.
- R11: Writing 0x01 with bit 0 clear has no effect on a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host register write strobe |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for bus_addr (combinational) |
| dsp_clk_ok | input | 1 | High while the DSP clock runs |
| sample_done | input | 1 | One-cycle strobe at the end of each DSP sample |
| dsp_rd_addr | input | 6 | DSP coefficient read address |
| dsp_rd_data | output | 24 | Coefficient word at dsp_rd_addr |

## Verification
Two collisions can fall in the same cycle as the boundary strobe: a host bus write and the commit of a pending request. The bench drives sample_done in the same cycle as a staging write and checks three things: the committed word is the value staged before that cycle, the new byte stays readable, and it commits only after a fresh request. In the same way, the bench places a request write on a strobe cycle, both with and without a request already pending. It then checks that the request bit still reads 1 and that the word lands only on the following strobe.

// File: rtl/coef_arb_pkg.sv
package coef_arb_pkg;

  localparam int COEF_W = 24;
  localparam int BUS_W  = 8;
  localparam int BUS_AW = 8;
  localparam int RAM_AW = 6;

  localparam logic [7:0] REG_CTRL  = 8'h01;
  localparam logic [7:0] REG_CADDR = 8'h02;
  localparam logic [7:0] REG_DATA  = 8'h03;

  // Word lands in one of the populated coefficient regions.
  function automatic logic coef_addr_mapped(input logic [7:0] a);
    return (a <= 8'h17) ||
           ((a >= 8'h20) && (a <= 8'h29)) ||
           (a == 8'h2C) || (a == 8'h2D);
  endfunction

endpackage

// File: rtl/coef_stage_regs.sv
module coef_stage_regs
  import coef_arb_pkg::*;
#(
  parameter int CW  = COEF_W,
  parameter int BW  = BUS_W,
  parameter int BAW = BUS_AW,
  parameter int AW  = RAM_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [BAW-1:0] bus_addr,
  input  logic [BW-1:0]  bus_wdata,
  input  logic           pending,
  input  logic [CW-1:0]  rb_data,
  output logic [AW-1:0]  stg_addr,
  output logic [CW-1:0]  stg_data,
  output logic           req_set,
  output logic [BW-1:0]  bus_rdata
);

  localparam int NB = CW / BW;
  localparam logic [BAW-1:0] A_CTRL  = BAW'(REG_CTRL);
  localparam logic [BAW-1:0] A_CADDR = BAW'(REG_CADDR);
  localparam logic [BAW-1:0] A_DATA  = BAW'(REG_DATA);
  localparam logic [BAW-1:0] A_RB    = BAW'(REG_DATA) + BAW'(NB);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] data_q, data_d;
  logic          addr_en, data_en;

  always_comb begin
    addr_d  = addr_q;
    data_d  = data_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    if (bus_we && (bus_addr == A_CADDR)) begin
      addr_en = 1'b1;
      addr_d  = bus_wdata[AW-1:0];
    end
    for (int k = 0; k < NB; k++) begin
      if (bus_we && (bus_addr == (A_DATA + BAW'(k)))) begin
        data_en = 1'b1;
        data_d[CW-1-k*BW -: BW] = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign req_set  = bus_we && (bus_addr == A_CTRL) && bus_wdata[0];
  assign stg_addr = addr_q;
  assign stg_data = data_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[0] = pending;
    end else if (bus_addr == A_CADDR) begin
      bus_rdata = BW'(addr_q);
    end
    for (int k = 0; k < NB; k++) begin
      if (bus_addr == (A_DATA + BAW'(k))) bus_rdata = data_q[CW-1-k*BW -: BW];
      if (bus_addr == (A_RB + BAW'(k)))   bus_rdata = rb_data[CW-1-k*BW -: BW];
    end
  end

  // R2: a staging write to the address register is held after the edge
  p_addr_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_CADDR)) |=> (stg_addr == $past(bus_wdata[AW-1:0])));

endmodule

// File: rtl/coef_commit_ctrl.sv
module coef_commit_ctrl
  import coef_arb_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int AW = RAM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_set,
  input  logic          dsp_clk_ok,
  input  logic          sample_done,
  input  logic [AW-1:0] stg_addr,
  input  logic [CW-1:0] stg_data,
  output logic          pending,
  output logic          ram_we,
  output logic [AW-1:0] ram_wa,
  output logic [CW-1:0] ram_wd
);

  logic pend_q, pend_d;
  logic commit;

  assign commit = pend_q && sample_done && dsp_clk_ok;

  always_comb begin
    pend_d = pend_q;
    if (!dsp_clk_ok) begin
      pend_d = 1'b0;
    end else if (req_set) begin
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
  assign ram_we  = commit && coef_addr_mapped(8'(stg_addr));
  assign ram_wa  = stg_addr;
  assign ram_wd  = stg_data;

  // R6: an absent DSP clock leaves no request pending
  p_drop_noclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_clk_ok |=> !pending);

  // R3: a request taken with the clock running is pending next cycle
  p_req_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set && dsp_clk_ok) |=> pending);

  // R4: a strobe with a pending request and no re-arm completes it
  p_commit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && sample_done && dsp_clk_ok && !req_set) |=> !pending);

  // R4: without a strobe and without a drop, a pending request is held
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !sample_done && dsp_clk_ok) |=> pending);

endmodule

// File: rtl/coef_ram.sv
module coef_ram
  import coef_arb_pkg::*;
#(
  parameter int CW = COEF_W,
  parameter int AW = RAM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [CW-1:0] wd,
  input  logic [AW-1:0] ra_host,
  output logic [CW-1:0] rd_host,
  input  logic [AW-1:0] ra_dsp,
  output logic [CW-1:0] rd_dsp
);

  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] mem_q [DEPTH];
  logic [CW-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = (we && (wa == AW'(i))) ? wd : mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_host = mem_q[ra_host];
  assign rd_dsp  = mem_q[ra_dsp];

  // R8: the controller never writes an unpopulated word
  p_mapped_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> coef_addr_mapped(8'(wa)));

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_hold
    // R4: a word changes only through the commit port
    p_word_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (wa == AW'(gi))) |=> $stable(mem_q[gi]));
  end

endmodule

// File: rtl/coef_readback.sv
module coef_readback
  import coef_arb_pkg::*;
#(
  parameter int CW = COEF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [CW-1:0] ram_word,
  output logic [CW-1:0] rb_data
);

  logic [CW-1:0] fetch_q, fetch_d;
  logic [CW-1:0] rb_q, rb_d;

  always_comb begin
    fetch_d = ram_word;
    rb_d    = fetch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= '0;
      rb_q    <= '0;
    end else if (bus_we) begin
      fetch_q <= fetch_d;
      rb_q    <= rb_d;
    end
  end

  assign rb_data = rb_q;

  // R9: readback moves only on a bus write
  p_rb_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(rb_data));

endmodule

// File: rtl/coef_write_arbiter.sv
module coef_write_arbiter
  import coef_arb_pkg::*;
#(
  parameter int CW  = COEF_W,
  parameter int BW  = BUS_W,
  parameter int BAW = BUS_AW,
  parameter int AW  = RAM_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [BAW-1:0] bus_addr,
  input  logic [BW-1:0]  bus_wdata,
  output logic [BW-1:0]  bus_rdata,
  input  logic           dsp_clk_ok,
  input  logic           sample_done,
  input  logic [AW-1:0]  dsp_rd_addr,
  output logic [CW-1:0]  dsp_rd_data
);

  logic [AW-1:0] stg_addr;
  logic [CW-1:0] stg_data;
  logic          req_set;
  logic          pending;
  logic          ram_we;
  logic [AW-1:0] ram_wa;
  logic [CW-1:0] ram_wd;
  logic [CW-1:0] host_word;
  logic [CW-1:0] rb_data;

  coef_stage_regs #(.CW(CW), .BW(BW), .BAW(BAW), .AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pending(pending), .rb_data(rb_data),
    .stg_addr(stg_addr), .stg_data(stg_data), .req_set(req_set),
    .bus_rdata(bus_rdata)
  );

  coef_commit_ctrl #(.CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .dsp_clk_ok(dsp_clk_ok),
    .sample_done(sample_done), .stg_addr(stg_addr), .stg_data(stg_data),
    .pending(pending), .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd)
  );

  coef_ram #(.CW(CW), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .wa(ram_wa), .wd(ram_wd),
    .ra_host(stg_addr), .rd_host(host_word),
    .ra_dsp(dsp_rd_addr), .rd_dsp(dsp_rd_data)
  );

  coef_readback #(.CW(CW)) u_rb (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .ram_word(host_word),
    .rb_data(rb_data)
  );

  // R7/R10: a commit stores the value staged before its edge
  p_commit_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (dsp_rd_addr != $past(ram_wa)) || (dsp_rd_data == $past(stg_data)));

endmodule

// File: tb/tb_coef_write_arbiter.sv
module tb_coef_write_arbiter;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        dsp_clk_ok;
  logic        sample_done;
  logic [5:0]  dsp_rd_addr;
  logic [23:0] dsp_rd_data;

  int checks = 0;
  int errors = 0;

  coef_write_arbiter dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsp_clk_ok(dsp_clk_ok),
    .sample_done(sample_done), .dsp_rd_addr(dsp_rd_addr), .dsp_rd_data(dsp_rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic strobe);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; sample_done = strobe;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; sample_done = 1'b0;
  endtask

  task automatic strobe();
    sample_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ram_word(input logic [5:0] a, output logic [23:0] d);
    dsp_rd_addr = a;
    #1 d = dsp_rd_data;
  endtask

  task automatic rb_word(output logic [23:0] d);
    logic [7:0] b2, b1, b0;
    rd(8'h06, b2); rd(8'h07, b1); rd(8'h08, b0);
    d = {b2, b1, b0};
  endtask

  task automatic stage(input logic [5:0] a, input logic [23:0] v);
    wr(8'h02, {2'b00, a}, 1'b0);
    wr(8'h03, v[23:16], 1'b0);
    wr(8'h04, v[15:8], 1'b0);
    wr(8'h05, v[7:0], 1'b0);
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [23:0] w;
    rd(8'h01, b); chk("R1", "ctrl after reset", 32'(b), 0);
    rb_word(w);   chk("R1", "readback after reset", 32'(w), 0);
    ram_word(6'h00, w); chk("R1", "word 0x00 after reset", 32'(w), 0);
    ram_word(6'h2D, w); chk("R1", "word 0x2D after reset", 32'(w), 0);
  endtask

  task automatic t_stage_commit();
    logic [7:0] b; logic [23:0] w;
    stage(6'h05, 24'h123456);
    rd(8'h02, b); chk("R2", "staged address", 32'(b), 32'h05);
    rd(8'h03, b); chk("R2", "staged high byte", 32'(b), 32'h12);
    rd(8'h04, b); chk("R2", "staged mid byte", 32'(b), 32'h34);
    rd(8'h05, b); chk("R2", "staged low byte", 32'(b), 32'h56);
    wr(8'h01, 8'h01, 1'b0);
    rd(8'h01, b); chk("R3", "request pending", 32'(b), 1);
    idle(5);
    rd(8'h01, b); chk("R3", "request held without strobe", 32'(b), 1);
    ram_word(6'h05, w); chk("R4", "no write before strobe", 32'(w), 0);
    strobe();
    rd(8'h01, b); chk("R4", "request cleared at commit", 32'(b), 0);
    ram_word(6'h05, w); chk("R4", "committed word", 32'(w), 32'h123456);
  endtask

  task automatic t_readback();
    logic [23:0] w;
    rb_word(w); chk("R9", "readback before dummy writes", 32'(w), 0);
    wr(8'h00, 8'h00, 1'b0);
    rb_word(w); chk("R9", "readback after one dummy write", 32'(w), 0);
    wr(8'h00, 8'h00, 1'b0);
    rb_word(w); chk("R9", "readback after two dummy writes", 32'(w), 32'h123456);
  endtask

  task automatic t_noclk();
    logic [7:0] b; logic [23:0] w;
    dsp_clk_ok = 1'b0;
    stage(6'h20, 24'h400000);
    wr(8'h01, 8'h01, 1'b0);
    rd(8'h01, b); chk("R6", "request dropped without clock", 32'(b), 0);
    strobe();
    ram_word(6'h20, w); chk("R6", "word unchanged without clock", 32'(w), 0);
    dsp_clk_ok = 1'b1;
    wr(8'h01, 8'h01, 1'b0);
    rd(8'h01, b); chk("R3", "request pending with clock", 32'(b), 1);
    dsp_clk_ok = 1'b0;
    idle(1);
    rd(8'h01, b); chk("R6", "pending request dropped on clock loss", 32'(b), 0);
    dsp_clk_ok = 1'b1;
    strobe();
    ram_word(6'h20, w); chk("R6", "word unchanged after dropped request", 32'(w), 0);
  endtask

  task automatic t_overwrite();
    logic [7:0] b; logic [23:0] w;
    stage(6'h21, 24'hAAAAAA);
    wr(8'h01, 8'h01, 1'b0);
    stage(6'h21, 24'h5A5A5A);
    wr(8'h01, 8'h00, 1'b0);
    rd(8'h01, b); chk("R11", "writing zero keeps request", 32'(b), 1);
    strobe();
    ram_word(6'h21, w); chk("R7", "latest staged value committed", 32'(w), 32'h5A5A5A);
  endtask

  task automatic t_unmapped();
    logic [7:0] b; logic [23:0] w;
    stage(6'h18, 24'h777777);
    wr(8'h01, 8'h01, 1'b0);
    strobe();
    rd(8'h01, b); chk("R8", "unmapped request completes", 32'(b), 0);
    ram_word(6'h18, w); chk("R8", "word 0x18 untouched", 32'(w), 0);
    stage(6'h2A, 24'h111111);
    wr(8'h01, 8'h01, 1'b0);
    strobe();
    ram_word(6'h2A, w); chk("R8", "word 0x2A untouched", 32'(w), 0);
    ram_word(6'h21, w); chk("R8", "mapped neighbour untouched", 32'(w), 32'h5A5A5A);
  endtask

  task automatic t_collide();
    logic [7:0] b; logic [23:0] w;
    // staging write in the commit cycle
    stage(6'h2C, 24'h0C0C0C);
    wr(8'h01, 8'h01, 1'b0);
    wr(8'h05, 8'hEE, 1'b1);
    ram_word(6'h2C, w); chk("R10", "commit uses earlier staged value", 32'(w), 32'h0C0C0C);
    rd(8'h05, b); chk("R10", "new byte stays staged", 32'(b), 32'hEE);
    rd(8'h01, b); chk("R10", "request cleared", 32'(b), 0);
    wr(8'h01, 8'h01, 1'b0);
    strobe();
    ram_word(6'h2C, w); chk("R10", "new value committed later", 32'(w), 32'h0C0CEE);
    // request written on a strobe with nothing pending
    stage(6'h2D, 24'h0D0D0D);
    wr(8'h01, 8'h01, 1'b1);
    rd(8'h01, b); chk("R5", "request on strobe stays pending", 32'(b), 1);
    ram_word(6'h2D, w); chk("R5", "no write on request strobe", 32'(w), 0);
    // re-arm on the commit strobe
    wr(8'h01, 8'h01, 1'b1);
    ram_word(6'h2D, w); chk("R5", "first commit", 32'(w), 32'h0D0D0D);
    rd(8'h01, b); chk("R5", "re-armed request pending", 32'(b), 1);
    wr(8'h03, 8'h99, 1'b0);
    strobe();
    ram_word(6'h2D, w); chk("R5", "re-armed commit", 32'(w), 32'h990D0D);
    rd(8'h01, b); chk("R5", "request cleared after second commit", 32'(b), 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    dsp_clk_ok = 1'b1; sample_done = 1'b0; dsp_rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_stage_commit();
    t_readback();
    t_noclk();
    t_overwrite();
    t_unmapped();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule